// File: doc/BRIEF.md
# Multi-Channel Audio Input Merger

This block gathers 32-bit audio words from eight independent serial receivers and funnels them through one shared queue. Every word carries a channel tag in its three least significant bits. On the read side the block looks at the tag of the oldest queued word and offers that word only on the matching one of eight valid/ready output ports. Software never has to select a destination.

Each receiver has its own clock and frame timing, so words reach the merger at unrelated times. Each input lane has a one-word holding register. A round-robin arbiter moves one held word per cycle into an 8-entry queue. A lane that never sends uses no queue space. If a lane's holding register is still occupied when another word arrives, the new word is dropped and a sticky per-lane overflow flag is raised. A 32-bit control register holds eight 3-bit receiver mode fields in bits [31:8]. These fields are driven straight out to the receivers.

Top module: `amerge_top`

## Requirements
- R1: After synchronous reset (active high) no output port is valid, all overflow flags are 0, and the control register and all mode outputs read 0.
- R2: A control write updates the control register on the next clock edge. Mode output field i (bits [3i+2:3i]) then equals control bits [8+3i+2:8+3i], with channel 0 in the lowest field.
- R3: A queued word is offered only on output port k, where k is the word's bits [2:0]. The lane it came from does not matter. At most one output port is valid at a time.
- R4: Words pass through unchanged. Words with the same tag leave in the order in which they were accepted.
- R5: Delivery is strictly in order. While the port addressed by the head word has ready low, that port stays valid with the same data and no other port becomes valid.
- R6: Lanes presenting words at the same time are served one per cycle in round-robin order. The lane after the most recently served lane has first priority, and lane 0 has first priority after reset.
- R7: A word that arrives on a lane whose holding register is full and is not moved out in that cycle is dropped. It sets that lane's overflow flag, which stays set until reset.
- R8: A single active lane with ready high streams one word per cycle at the output, and idle lanes take no queue slots.
- R9: When the queue is full, held words wait in their holding registers and are delivered once space frees. A single waiting word on another lane raises no overflow.
- R10: Reset discards all queued and held words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 8 | Per-lane word strobe from the receivers |
| in_data | input | 256 | Per-lane words, lane i at bits [32i+31:32i] |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 32 | Control register write data |
| ctl_q | output | 32 | Control register contents |
| mode_out | output | 24 | Per-lane 3-bit receiver mode, lane i at bits [3i+2:3i] |
| ovf | output | 8 | Sticky per-lane overflow flags |
| out_valid | output | 8 | Per-port valid; at most one is high |
| out_data | output | 32 | Head word, shared by all ports |
| out_ready | input | 8 | Per-port ready from the consumers |

## Verification
The bound checker checks several properties on every cycle:
- at most one port is valid;
- a valid port's index equals the tag of the presented word;
- a stalled head keeps its port and data;
- overflow flags never clear without reset;
- mode outputs follow a control write one cycle later;
- the block comes out of reset empty.

Other properties depend on the history of traffic, and only the bench scenarios show them: the rotation order of the arbiter, exactly which word is dropped at overflow, back-to-back streaming rate, and the flushing of pending words by reset. The scoreboard compares every delivered word against per-port queues.

// File: rtl/amerge_pkg.sv
package amerge_pkg;
  // Width of the control register and placement of the per-lane mode fields
  localparam int CTL_W    = 32;
  localparam int MODE_LSB = 8;
  localparam int MODE_W   = 3;
endpackage

// File: rtl/amerge_rr_arb.sv
// Round-robin arbiter: the lane after the last winner has first priority.
module amerge_rr_arb #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 gnt_any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;
  logic [IW-1:0] cand;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    cand    = '0;
    for (int off = 0; off < N; off++) begin
      cand = ptr + IW'(off);
      if (!gnt_any && req[cand]) begin
        gnt_any   = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (gnt_any) ptr <= gnt_idx + IW'(1);
  end
endmodule

// File: rtl/amerge_skid.sv
// One-word holding register per input lane with a sticky drop flag.
module amerge_skid #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          ovf
);
  logic accept;
  assign accept = in_valid && (!full || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (in_valid && !accept) ovf <= 1'b1;
      if (accept)              full <= 1'b1;
      else if (take)           full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) data <= in_data;
  end
endmodule

// File: rtl/amerge_fifo.sv
// Shared word queue; storage has no reset so it can map to RAM.
module amerge_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/amerge_route.sv
// Registered head stage: offers the head word on the port named by its tag.
module amerge_route #(
  parameter int N  = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          q_empty,
  input  logic [DW-1:0] q_data,
  output logic          q_pop,
  input  logic [N-1:0]  out_ready,
  output logic [N-1:0]  out_valid,
  output logic [DW-1:0] out_data
);
  localparam int TW = $clog2(N);

  logic          hv;
  logic [DW-1:0] hd;
  logic [TW-1:0] tag;
  logic          fire;

  assign tag      = hd[TW-1:0];
  assign fire     = hv && out_ready[tag];
  assign q_pop    = !q_empty && (!hv || fire);
  assign out_data = hd;

  always_ff @(posedge clk) begin
    if (rst)        hv <= 1'b0;
    else if (q_pop) hv <= 1'b1;
    else if (fire)  hv <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (q_pop) hd <= q_data;
  end

  for (genvar i = 0; i < N; i++) begin : g_port
    assign out_valid[i] = hv && (tag == TW'(i));
  end
endmodule

// File: rtl/amerge_ctl.sv
// Control register and fan-out of the per-lane mode fields.
module amerge_ctl
  import amerge_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTL_W-1:0]  wdata,
  output logic [CTL_W-1:0]  q,
  output logic [N*MODE_W-1:0] mode
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end

  for (genvar i = 0; i < N; i++) begin : g_mode
    assign mode[i*MODE_W +: MODE_W] = q[MODE_LSB + i*MODE_W +: MODE_W];
  end
endmodule

// File: rtl/amerge_top.sv
module amerge_top
  import amerge_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        in_valid,
  input  logic [NCH*DW-1:0]     in_data,
  input  logic                  ctl_we,
  input  logic [CTL_W-1:0]      ctl_wdata,
  output logic [CTL_W-1:0]      ctl_q,
  output logic [NCH*MODE_W-1:0] mode_out,
  output logic [NCH-1:0]        ovf,
  output logic [NCH-1:0]        out_valid,
  output logic [DW-1:0]         out_data,
  input  logic [NCH-1:0]        out_ready
);
  localparam int IW = $clog2(NCH);

  logic [NCH-1:0]  hold_full;
  logic [DW-1:0]   hold_data [NCH];
  logic [NCH-1:0]  req, gnt;
  logic [IW-1:0]   gnt_idx;
  logic            gnt_any;
  logic            q_full, q_empty, q_pop;
  logic [DW-1:0]   q_data;

  amerge_ctl #(.N(NCH)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .q(ctl_q), .mode(mode_out)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    amerge_skid #(.DW(DW)) u_skid (
      .clk(clk), .rst(rst),
      .in_valid(in_valid[i]), .in_data(in_data[i*DW +: DW]),
      .take(gnt[i]), .full(hold_full[i]), .data(hold_data[i]),
      .ovf(ovf[i])
    );
  end

  assign req = hold_full & {NCH{!q_full}};

  amerge_rr_arb #(.N(NCH)) u_arb (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt),
    .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  amerge_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(gnt_any), .wdata(hold_data[gnt_idx]),
    .pop(q_pop), .rdata(q_data),
    .full(q_full), .empty(q_empty)
  );

  amerge_route #(.N(NCH), .DW(DW)) u_route (
    .clk(clk), .rst(rst),
    .q_empty(q_empty), .q_data(q_data), .q_pop(q_pop),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/amerge_chk.sv
module amerge_chk #(
  parameter int NCH   = 8,
  parameter int DW    = 32,
  parameter int MW    = 24
) (
  input logic           clk,
  input logic           rst,
  input logic           ctl_we,
  input logic [MW-1:0]  mode_wr,
  input logic [MW-1:0]  mode_out,
  input logic [NCH-1:0] ovf,
  input logic [NCH-1:0] out_valid,
  input logic [DW-1:0]  out_data,
  input logic [NCH-1:0] out_ready
);
  localparam int TW = $clog2(NCH);

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_valid == '0 && ovf == '0));

  // R2
  mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (mode_out == $past(mode_wr)));

  // R3
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|(out_valid & ~out_ready)) |=> ($stable(out_valid) && $stable(out_data)));

  for (genvar i = 0; i < NCH; i++) begin : g_port
    // R3
    tag_match_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid[i] |-> (out_data[TW-1:0] == TW'(i)));
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf[i] |=> ovf[i]);
  end
endmodule

bind amerge_top amerge_chk #(.NCH(NCH), .DW(DW), .MW(NCH*amerge_pkg::MODE_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we),
  .mode_wr(ctl_wdata[amerge_pkg::MODE_LSB +: NCH*amerge_pkg::MODE_W]),
  .mode_out(mode_out), .ovf(ovf), .out_valid(out_valid),
  .out_data(out_data), .out_ready(out_ready)
);

// File: tb/amerge_top_tb.sv
`timescale 1ns/1ps
module amerge_top_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   in_valid = '0;
  logic [255:0] in_data = '0;
  logic         ctl_we = 1'b0;
  logic [31:0]  ctl_wdata = '0;
  logic [31:0]  ctl_q;
  logic [23:0]  mode_out;
  logic [7:0]   ovf;
  logic [7:0]   out_valid;
  logic [31:0]  out_data;
  logic [7:0]   out_ready = '1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] expq [8][$];
  logic [31:0] got_log [$];
  int          got_cyc [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  amerge_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .mode_out(mode_out), .ovf(ovf), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: samples just before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #9;
      if (!rst) begin
        for (int i = 0; i < 8; i++) begin
          if (out_valid[i] && out_ready[i]) begin
            check(out_data[2:0] == 3'(i), "R3 port/tag", {29'd0, out_data[2:0]}, i);
            if (expq[i].size() == 0) begin
              check(1'b0, "R4 unexpected word", out_data, 32'h0);
            end else begin
              logic [31:0] e;
              e = expq[i].pop_front();
              check(out_data == e, "R4 word", out_data, e);
            end
            got_log.push_back(out_data);
            got_cyc.push_back(cyc);
          end
        end
      end
    end
  end

  task automatic clear_log();
    got_log.delete();
    got_cyc.delete();
  endtask

  task automatic send_mask(input logic [7:0] mask, input logic [31:0] base);
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      if (mask[c]) begin
        logic [31:0] w;
        w = {base[31:8], 5'(c), 3'(c)};
        in_valid[c] = 1'b1;
        in_data[c*32 +: 32] = w;
        expq[c].push_back(w);
      end
    end
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic stream(input int ch, input int n, input int nexp, input logic [31:0] base);
    for (int k = 0; k < n; k++) begin
      logic [31:0] w;
      @(negedge clk);
      w = {base[31:16], 8'(k), 5'd0, 3'(ch)};
      in_valid[ch] = 1'b1;
      in_data[ch*32 +: 32] = w;
      if (k < nexp) expq[ch].push_back(w);
    end
    @(negedge clk);
    in_valid[ch] = 1'b0;
  endtask

  task automatic drain(input string req);
    int left;
    for (int t = 0; t < 300; t++) begin
      left = 0;
      for (int i = 0; i < 8; i++) left += expq[i].size();
      if (left == 0) break;
      @(negedge clk);
    end
    left = 0;
    for (int i = 0; i < 8; i++) left += expq[i].size();
    check(left == 0, req, left, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [31:0] v);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    check(ctl_q == v, "R2 ctl_q", ctl_q, v);
    for (int i = 0; i < 8; i++)
      check(mode_out[i*3 +: 3] == v[8 + i*3 +: 3], "R2 mode field",
            {29'd0, mode_out[i*3 +: 3]}, {29'd0, v[8 + i*3 +: 3]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(out_valid == '0, "R1 out_valid", {24'd0, out_valid}, 0);
    check(ovf == '0, "R1 ovf", {24'd0, ovf}, 0);
    check(ctl_q == '0 && mode_out == '0, "R1 ctl", ctl_q, 0);

    // R2: mode field fan-out
    ctl_write(32'hDEADBE5A);
    ctl_write(32'h00A5C3FF);

    // R4: single lane sequence, unchanged data, same order
    stream(3, 5, 5, 32'h3A3A0000);
    drain("R4 drain");

    // R3: routing by tag, not by source lane
    @(negedge clk);
    in_valid[1] = 1'b1;
    in_data[32 +: 32] = 32'hC0DE0016;
    expq[6].push_back(32'hC0DE0016);
    @(negedge clk);
    in_valid[1] = 1'b0;
    drain("R3 drain");

    // R6: round robin starting after the last served lane
    send_mask(8'h80, 32'h77000000);
    drain("R6 drain a");
    clear_log();
    send_mask(8'hFF, 32'h11000000);
    drain("R6 drain b");
    check(got_log.size() == 8, "R6 count", got_log.size(), 8);
    for (int k = 0; k < 8 && k < got_log.size(); k++)
      check(got_log[k][2:0] == 3'(k), "R6 order 0..7", {29'd0, got_log[k][2:0]}, k);
    send_mask(8'h20, 32'h55000000);
    drain("R6 drain c");
    clear_log();
    send_mask(8'hFF, 32'h22000000);
    drain("R6 drain d");
    for (int k = 0; k < 8 && k < got_log.size(); k++)
      check(got_log[k][2:0] == 3'((k + 6) % 8), "R6 rotated order",
            {29'd0, got_log[k][2:0]}, (k + 6) % 8);

    // R8: back-to-back streaming of one lane, others idle
    clear_log();
    stream(0, 8, 8, 32'h0B0B0000);
    drain("R8 drain");
    check(got_cyc.size() == 8, "R8 count", got_cyc.size(), 8);
    if (got_cyc.size() == 8)
      check(got_cyc[7] - got_cyc[0] == 7, "R8 one per cycle", got_cyc[7] - got_cyc[0], 7);
    check(ovf == '0, "R8 no overflow", {24'd0, ovf}, 0);

    // R5: stalled head blocks later word on another port
    clear_log();
    out_ready[2] = 1'b0;
    send_mask(8'h04, 32'hAAAA0000);
    send_mask(8'h08, 32'hBBBB0000);
    repeat (6) @(negedge clk);
    check(out_valid == 8'h04, "R5 stalled port", {24'd0, out_valid}, 32'h04);
    check(out_data == 32'hAAAA0012, "R5 head data", out_data, 32'hAAAA0012);
    out_ready[2] = 1'b1;
    drain("R5 drain");
    check(got_log.size() == 2 && got_log[0] == 32'hAAAA0012, "R5 order",
          got_log.size() > 0 ? got_log[0] : 32'h0, 32'hAAAA0012);

    // R7 / R9: overflow with queue full; a single word on lane 4 waits
    out_ready = '0;
    stream(0, 11, 10, 32'h0F0F0000);
    send_mask(8'h10, 32'h44000000);
    repeat (2) @(negedge clk);
    check(ovf == 8'h01, "R7 overflow flag", {24'd0, ovf}, 32'h01);
    check(out_valid == 8'h01 && out_data == 32'h0F0F0000, "R9 head held",
          out_data, 32'h0F0F0000);
    out_ready = '1;
    drain("R9 drain");
    check(ovf == 8'h01, "R7 sticky", {24'd0, ovf}, 32'h01);

    // R10: reset flushes pending words and clears flags
    out_ready = '0;
    send_mask(8'h40, 32'h66000000);
    send_mask(8'h40, 32'h67000000);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 8; i++) expq[i].delete();
    @(negedge clk);
    rst = 1'b0;
    out_ready = '1;
    repeat (10) @(negedge clk);
    check(out_valid == '0, "R10 flushed", {24'd0, out_valid}, 0);
    check(ovf == '0, "R10 ovf cleared", {24'd0, ovf}, 0);
    check(ctl_q == '0, "R10 ctl cleared", ctl_q, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule